// File: doc/BRIEF.md
# CAN Bit Timing and Sampling Unit

This unit turns the system clock into the bit-level time base for a CAN controller. A prescaler produces time quanta. Each nominal bit is then walked through four segments: a one-quantum synchronisation slot, a propagation slot, a first phase slot and a second phase slot. At the boundary between the two phase slots the unit latches the bus value and raises a one-cycle sample strobe. At the end of the bit it raises a one-cycle transmit strobe, which tells the frame logic to present its next bit.

Recessive-to-dominant transitions on the receive line are used for soft resynchronisation. An early transition stretches the first phase slot and a late one trims the second, by no more than the programmed jump width. A hard-sync request from the frame logic at start of frame restarts the bit from its synchronisation slot. The value can be decided by a single sample or by a three-sample majority. The second phase slot is either programmed directly or derived from the first phase slot and the processing time.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts 2×(cfg_brp+1) clock cycles. Quanta restart counting on the edge that takes hsync_req.
- R2: A bit is 1 quantum of sync, then cfg_prseg+1 quanta of propagation, then PS1 = cfg_phseg1+1 quanta, then PS2 quanta. sample_pt is high for one cycle right after the clock edge that ends PS1, and tx_pt is high for one cycle right after the edge that ends PS2.
- R3: With cfg_ps2_prog=1, PS2 is cfg_phseg2+1 quanta, except that a value of 0 gives 2 quanta.
- R4: With cfg_ps2_prog=0, PS2 is the larger of PS1 and the 2-quantum processing time.
- R5: sample_pt and tx_pt are never high in the same cycle.
- R6: With cfg_sam=0, rx_bit takes rx_in at the edge ending PS1. With cfg_sam=1 it takes the majority of rx_in at that edge and at the ends of the two quanta before it. rx_bit changes at no other edge, and 1 is recessive.
- R7: Soft resynchronisation happens on a 1→0 change of rx_in between two consecutive edges. It applies only outside the sync slot, at most once per bit, and only while rx_bit is 1 (recessive).
- R8: A resync edge in the propagation slot or in PS1 lengthens PS1 by min(e, cfg_sjw+1). Here e counts the propagation and PS1 quanta begun so far, including the current one.
- R9: A resync edge in PS2 shortens PS2 by min(e, cfg_sjw+1). Here e counts the PS2 quanta not yet finished, including the current one.
- R10: An edge that takes hsync_req=1 puts the unit at the start of the sync quantum, cancels pending resync adjustments and leaves both strobes low in the following cycle.
- R11: After reset, sample_pt and tx_pt are low and rx_bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_brp | input | 6 | Prescaler setting |
| cfg_prseg | input | 3 | Propagation slot length minus one |
| cfg_phseg1 | input | 3 | First phase slot length minus one |
| cfg_phseg2 | input | 3 | Second phase slot length minus one (programmed mode) |
| cfg_sjw | input | 2 | Jump width minus one |
| cfg_sam | input | 1 | 1 = three-sample majority |
| cfg_ps2_prog | input | 1 | 1 = PS2 from cfg_phseg2, 0 = derived |
| hsync_req | input | 1 | Hard-sync request |
| rx_in | input | 1 | Bus receive line |
| sample_pt | output | 1 | One-cycle strobe at the sample point |
| tx_pt | output | 1 | One-cycle strobe at the end of the bit |
| rx_bit | output | 1 | Sampled bit value |

## Verification
All results are timed from the edge that accepts hsync_req. If that edge is h and the quantum length is L, the n-th quantum boundary falls at edge h+n·L. A strobe and the sampled value become visible in the cycle after their boundary edge, so the sample point of bit k is due at h+L·((1+prop+PS1)+k·bit), and tx_pt and rx_bit follow the same rule. The driver pushes each expected cycle number and bit value into queues. It applies rx_in changes at chosen cycles to place glitches and resync edges in a known slot. The monitor pops the queues at falling clock edges, only while a test window is open, and compares the cycle count and the value exactly.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    localparam int unsigned LEN_W = 5;

    typedef logic [LEN_W-1:0] len_t;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;

    typedef struct packed {
        seg_e  seg;
        len_t  qcnt;
        len_t  ext;
        len_t  shrink;
        logic  synced;
        logic  rx_prev;
        logic  sp;
        logic  tx;
    } fsm_state_t;

    function automatic len_t len_min(len_t a, len_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic len_t len_max(len_t a, len_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
    parameter int unsigned BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [BRP_W-1:0] brp,
    output logic             tick
);
    localparam int unsigned CNT_W = BRP_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q, last;

    always_comb begin
        last  = {brp, 1'b1};
        tick  = (cnt_q >= last);
        cnt_d = (restart || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: a quantum is never shorter than two clocks
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> !tick);

endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sp_event,
    input  logic rx,
    input  logic three,
    output logic bit_val
);
    logic [1:0] sh_d, sh_q;
    logic       bit_d, bit_q, maj;

    always_comb begin
        sh_d  = tick ? {sh_q[0], rx} : sh_q;
        maj   = (sh_q[1] & sh_q[0]) | (sh_q[1] & rx) | (sh_q[0] & rx);
        bit_d = sp_event ? (three ? maj : rx) : bit_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= 2'b11;
            bit_q <= 1'b1;
        end else begin
            sh_q  <= sh_d;
            bit_q <= bit_d;
        end
    end

    assign bit_val = bit_q;

    // R6: the bit value only moves at a sample point
    a_r6_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_event |=> $stable(bit_q));

endmodule

// File: rtl/cbt_bit_fsm.sv
module cbt_bit_fsm
    import cbt_pkg::*;
#(
    parameter int unsigned SEG_W  = 3,
    parameter int unsigned SJW_W  = 2,
    parameter int unsigned IPT_TQ = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hsync,
    input  logic             rx,
    input  logic             bit_val,
    input  logic [SEG_W-1:0] prseg,
    input  logic [SEG_W-1:0] phseg1,
    input  logic [SEG_W-1:0] phseg2,
    input  logic [SJW_W-1:0] sjw,
    input  logic             ps2_prog,
    output logic             sp_event,
    output logic             sample_pt,
    output logic             tx_pt
);
    localparam len_t IPT_LEN = len_t'(IPT_TQ);
    localparam len_t PS2_MIN = len_t'(2);

    fsm_state_t q, d;
    len_t prop_len, ps1_base, ps2_base, jump, err, ps1_now, ps2_now;
    logic fall;

    always_comb begin
        prop_len = len_t'(prseg) + 1'b1;
        ps1_base = len_t'(phseg1) + 1'b1;
        ps2_base = ps2_prog ? len_max(len_t'(phseg2) + 1'b1, PS2_MIN)
                            : len_max(ps1_base, IPT_LEN);
        jump     = len_t'(sjw) + 1'b1;
        err      = '0;

        d         = q;
        d.sp      = 1'b0;
        d.tx      = 1'b0;
        d.rx_prev = rx;
        fall      = q.rx_prev & ~rx;

        if (fall && !q.synced && bit_val && (q.seg != SEG_SYNC)) begin
            d.synced = 1'b1;
            unique case (q.seg)
                SEG_PROP: begin
                    err   = q.qcnt + 1'b1;
                    d.ext = len_min(err, jump);
                end
                SEG_PH1: begin
                    err   = prop_len + q.qcnt + 1'b1;
                    d.ext = len_min(err, jump);
                end
                default: begin
                    err      = (ps2_base - q.shrink) - q.qcnt;
                    d.shrink = len_min(err, jump);
                end
            endcase
        end

        ps1_now = ps1_base + d.ext;
        ps2_now = ps2_base - d.shrink;

        if (tick) begin
            unique case (q.seg)
                SEG_SYNC: begin
                    d.seg  = SEG_PROP;
                    d.qcnt = '0;
                end
                SEG_PROP: begin
                    if (q.qcnt + 1'b1 >= prop_len) begin
                        d.seg  = SEG_PH1;
                        d.qcnt = '0;
                    end else d.qcnt = q.qcnt + 1'b1;
                end
                SEG_PH1: begin
                    if (q.qcnt + 1'b1 >= ps1_now) begin
                        d.seg  = SEG_PH2;
                        d.qcnt = '0;
                        d.sp   = 1'b1;
                    end else d.qcnt = q.qcnt + 1'b1;
                end
                default: begin
                    if (q.qcnt + 1'b1 >= ps2_now) begin
                        d.seg    = SEG_SYNC;
                        d.qcnt   = '0;
                        d.tx     = 1'b1;
                        d.ext    = '0;
                        d.shrink = '0;
                        d.synced = 1'b0;
                    end else d.qcnt = q.qcnt + 1'b1;
                end
            endcase
        end

        if (hsync) begin
            d.seg    = SEG_SYNC;
            d.qcnt   = '0;
            d.ext    = '0;
            d.shrink = '0;
            d.synced = 1'b0;
            d.sp     = 1'b0;
            d.tx     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.seg     <= SEG_SYNC;
            q.rx_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sp_event  = d.sp;
    assign sample_pt = q.sp;
    assign tx_pt     = q.tx;

    // R5: strobes are exclusive
    a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_pt, tx_pt}));

    // R2: the sync slot is exactly one quantum
    a_r2_sync_len: assert property (@(posedge clk) disable iff (!rst_n)
        (q.seg == SEG_SYNC && tick && !hsync) |=> (q.seg == SEG_PROP));

    // R7: only one adjustment per bit
    a_r7_single_jump: assert property (@(posedge clk) disable iff (!rst_n)
        !((q.ext != '0) && (q.shrink != '0)));

    // R10: no strobe follows a hard sync
    a_r10_hsync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> (!sample_pt && !tx_pt));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
    parameter int unsigned BRP_W  = 6,
    parameter int unsigned SEG_W  = 3,
    parameter int unsigned SJW_W  = 2,
    parameter int unsigned IPT_TQ = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] cfg_brp,
    input  logic [SEG_W-1:0] cfg_prseg,
    input  logic [SEG_W-1:0] cfg_phseg1,
    input  logic [SEG_W-1:0] cfg_phseg2,
    input  logic [SJW_W-1:0] cfg_sjw,
    input  logic             cfg_sam,
    input  logic             cfg_ps2_prog,
    input  logic             hsync_req,
    input  logic             rx_in,
    output logic             sample_pt,
    output logic             tx_pt,
    output logic             rx_bit
);
    logic tick, sp_event;

    cbt_prescaler #(.BRP_W(BRP_W)) presc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (hsync_req),
        .brp     (cfg_brp),
        .tick    (tick)
    );

    cbt_bit_fsm #(.SEG_W(SEG_W), .SJW_W(SJW_W), .IPT_TQ(IPT_TQ)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hsync     (hsync_req),
        .rx        (rx_in),
        .bit_val   (rx_bit),
        .prseg     (cfg_prseg),
        .phseg1    (cfg_phseg1),
        .phseg2    (cfg_phseg2),
        .sjw       (cfg_sjw),
        .ps2_prog  (cfg_ps2_prog),
        .sp_event  (sp_event),
        .sample_pt (sample_pt),
        .tx_pt     (tx_pt)
    );

    cbt_sampler samp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .sp_event (sp_event),
        .rx       (rx_in),
        .three    (cfg_sam),
        .bit_val  (rx_bit)
    );

endmodule

// File: tb/can_bit_timer_tb_top.sv
`timescale 1ns/1ps
module can_bit_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_brp = '0;
    logic [2:0] cfg_prseg = '0, cfg_phseg1 = '0, cfg_phseg2 = '0;
    logic [1:0] cfg_sjw = '0;
    logic       cfg_sam = 1'b0, cfg_ps2_prog = 1'b1;
    logic       hsync_req = 1'b0, rx_in = 1'b1;
    logic       sample_pt, tx_pt, rx_bit;

    int checks = 0, fails = 0, cyc = 0, overlap = 0;
    logic mon_on = 1'b0;
    int    sp_cyc[$];
    logic  sp_bit[$];
    string sp_tag[$];
    int    tx_cyc[$];
    string tx_tag[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    can_bit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_brp(cfg_brp), .cfg_prseg(cfg_prseg),
        .cfg_phseg1(cfg_phseg1), .cfg_phseg2(cfg_phseg2), .cfg_sjw(cfg_sjw),
        .cfg_sam(cfg_sam), .cfg_ps2_prog(cfg_ps2_prog), .hsync_req(hsync_req),
        .rx_in(rx_in), .sample_pt(sample_pt), .tx_pt(tx_pt), .rx_bit(rx_bit)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops expectations as strobes appear
    always @(negedge clk) begin
        if (rst_n && sample_pt && tx_pt) overlap++;
        if (mon_on && sample_pt) begin
            if (sp_cyc.size() == 0) check("R2 unexpected sample_pt cycle", cyc, -1);
            else begin
                check({sp_tag[0], " sample cycle"}, cyc, sp_cyc[0]);
                check({sp_tag[0], " rx_bit"}, int'(rx_bit), int'(sp_bit[0]));
                void'(sp_cyc.pop_front()); void'(sp_bit.pop_front()); void'(sp_tag.pop_front());
            end
        end
        if (mon_on && tx_pt) begin
            if (tx_cyc.size() == 0) check("R2 unexpected tx_pt cycle", cyc, -1);
            else begin
                check({tx_tag[0], " tx cycle"}, cyc, tx_cyc[0]);
                void'(tx_cyc.pop_front()); void'(tx_tag.pop_front());
            end
        end
    end

    task automatic exp_sp(int c, logic b, string tag);
        sp_cyc.push_back(c); sp_bit.push_back(b); sp_tag.push_back(tag);
    endtask

    task automatic exp_tx(int c, string tag);
        tx_cyc.push_back(c); tx_tag.push_back(tag);
    endtask

    task automatic wait_cyc(int c);
        while (cyc < c) @(negedge clk);
    endtask

    // applies config, pulses hard sync, returns the accepting edge index
    task automatic start(input int brp, prseg, ph1, ph2, sjw, sam, prog,
                         input logic rxv, output int h);
        @(negedge clk);
        cfg_brp = 6'(brp); cfg_prseg = 3'(prseg); cfg_phseg1 = 3'(ph1);
        cfg_phseg2 = 3'(ph2); cfg_sjw = 2'(sjw); cfg_sam = sam[0];
        cfg_ps2_prog = prog[0]; rx_in = rxv; hsync_req = 1'b1;
        @(negedge clk);
        hsync_req = 1'b0;
        h = cyc;
        mon_on = 1'b1;
    endtask

    task automatic finish_test(string tag);
        int t = 0;
        while ((sp_cyc.size() != 0 || tx_cyc.size() != 0) && t < 4000) begin
            @(negedge clk); t++;
        end
        check({tag, " pending expectations"}, sp_cyc.size() + tx_cyc.size(), 0);
        mon_on = 1'b0;
        sp_cyc.delete(); sp_bit.delete(); sp_tag.delete();
        tx_cyc.delete(); tx_tag.delete();
    endtask

    task automatic plain_test(int brp, prseg, ph1, ph2, sam, prog, logic rxv,
                              int nbits, string tag);
        int h, l, prop, ps1, ps2, bitq;
        l    = 2 * (brp + 1);
        prop = prseg + 1;
        ps1  = ph1 + 1;
        if (prog != 0) ps2 = (ph2 == 0) ? 2 : ph2 + 1;
        else           ps2 = (ps1 > 2) ? ps1 : 2;
        bitq = 1 + prop + ps1 + ps2;
        start(brp, prseg, ph1, ph2, 0, sam, prog, rxv, h);
        for (int k = 0; k < nbits; k++) begin
            exp_sp(h + l * (1 + prop + ps1) + k * l * bitq, rxv, tag);
            exp_tx(h + l * bitq * (k + 1), tag);
        end
        finish_test(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 sample_pt", int'(sample_pt), 0);
        check("R11 tx_pt", int'(tx_pt), 0);
        check("R11 rx_bit", int'(rx_bit), 1);

        // R1 R2 R3 R6 R10: programmed PS2, single sample, recessive
        plain_test(0, 1, 2, 3, 0, 1, 1'b1, 3, "R1,R2,R3,R10");
        // R1 R4: derived PS2 with PS1 below processing time, dominant
        plain_test(2, 0, 0, 5, 0, 0, 1'b0, 2, "R1,R4");
        // R3: programmed PS2 of 0 clamps to 2 quanta
        plain_test(1, 2, 4, 0, 0, 1, 1'b0, 2, "R3 clamp");

        // R6 R7: majority vote, dominant baseline so no resync
        start(0, 0, 2, 1, 0, 1, 1, 1'b0, h);
        exp_sp(h + 10, 1'b0, "R6,R7 majority one of three");
        exp_tx(h + 14, "R6,R7");
        exp_sp(h + 24, 1'b1, "R6,R7 majority two of three");
        exp_tx(h + 28, "R6,R7");
        wait_cyc(h + 7);  rx_in = 1'b1;
        wait_cyc(h + 8);  rx_in = 1'b0;
        wait_cyc(h + 19); rx_in = 1'b1;
        wait_cyc(h + 22); rx_in = 1'b0;
        finish_test("R6");

        // R4: derived PS2 equals a long PS1
        plain_test(0, 0, 5, 0, 0, 0, 1'b1, 2, "R4 long");

        // R8: edge in propagation slot, error 2 limited to jump 1
        start(0, 1, 2, 3, 0, 0, 1, 1'b1, h);
        exp_sp(h + 14, 1'b0, "R8 lengthen");
        exp_tx(h + 22, "R8");
        exp_sp(h + 34, 1'b0, "R8 next bit");
        exp_tx(h + 42, "R8");
        wait_cyc(h + 4); rx_in = 1'b0;
        finish_test("R8");

        // R9: edge in PS2, two quanta left, jump 4 -> trims 2
        start(0, 1, 2, 3, 3, 0, 1, 1'b1, h);
        exp_sp(h + 12, 1'b1, "R9 first bit");
        exp_tx(h + 18, "R9 shorten");
        exp_sp(h + 30, 1'b0, "R9 next bit");
        exp_tx(h + 38, "R9");
        wait_cyc(h + 16); rx_in = 1'b0;
        finish_test("R9");

        check("R5 strobe overlap cycles", overlap, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule